// File: doc/BRIEF.md
# LED Matrix Row Scanner with Duty-Cycle Dimming

This block refreshes an eight-character, 5x7 dot LED array. It walks the seven dot rows in turn. For each row it fetches that row's dots for every character from a dot RAM read port and drives them onto a 40-bit column bus. A one-hot strobe lights the row. The scan advances only on a mux-clock enable pulse in the system clock domain. An optional divide-by-16 stage can sit in front of the timing counter, so a fast enable source still gives the usual refresh rate.

Each row owns a fixed slot of 64 scan steps. Brightness is set by how much of the slot the strobe stays on. Eight codes map onto a nonlinear duty table, and the darkest code blanks the panel completely while the RAM side keeps working. A separate peak-current select bit is passed to the LED driver as a registered flag and has no effect on duty.

Top module: `led_row_scanner`

## Requirements
- R1: While reset is high and on the first cycle after it, the row counter and the slot counter are zero, the column bus is all zero, and the strobe selects row 0 for any nonzero on-time.
- R2: At most one strobe bit is high at any time. Row r is bit r. Rows are served in the order 0,1,...,6 and then back to 0, and each row lasts exactly 64 scan steps.
- R3: The column bus carries character c's dots on bits [5c+4:5c]. While row r is shown, the bus holds the RAM word for row r. The RAM row address output names the row that comes next, and its word is captured on the last scan step of the current slot. The very first slot after reset shows all zero.
- R4: The strobe is high from slot step 0 up to, but not including, the on-time. The on-time is 64, 34, 26, 17, 13, 8, 4 or 0 steps for brightness codes 0 to 7.
- R5: Code 7 is power-down: the strobe stays all zero. Column words are still fetched, so RAM contents changed during power-down appear once the panel is relit. Any other code relights the strobe in the same cycle it is applied.
- R6: The peak-current flag equals the peak-select input as it was one clock earlier. It does not depend on the brightness code.
- R7: With the divide control set, one scan step takes 16 enable pulses. With it clear, every enable pulse is one scan step.
- R8: A change to the RAM word of the row being shown does not alter the column bus before that row's next slot.
- R9: Cycles without an enable pulse change neither the column bus, the strobe nor the RAM row address.
- R10: A reset asserted in the middle of a scan restarts it at row 0, slot step 0, with the column bus cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_tick | input | 1 | Single-cycle mux-clock enable |
| div16_en | input | 1 | 1: scan step every 16 enables, 0: every enable |
| bright_code | input | 3 | Brightness code, 0 brightest, 7 power-down |
| peak_sel | input | 1 | Peak-current select, 1 full, 0 reduced |
| ram_rd_row | output | 3 | Row address presented to the dot RAM |
| ram_rd_data | input | 40 | Dot word for that row, 5 bits per character |
| row_strobe | output | 7 | One-hot row drive |
| col_en | output | 40 | Column enables for all characters |
| peak_flag | output | 1 | Registered peak-current indication |

## Verification
The bench counts the strobe-high steps in a full slot for every code. A design with an off-by-one in the on-time compare would come up one step long or short. A wrong table entry would miss for a single code. It holds the enable low for long stretches, which catches counters that run on the system clock. It also crosses slot boundaries with and without the prescaler, so a divider that wraps at 15 or 17, or a slot of 63 or 65 steps, lands on the wrong row. RAM words are changed in the middle of a slot and during power-down. A design that shows RAM live would change the lit row at once, and one that stops fetching while dark would come back showing stale dots.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int DUTY_STEPS = 8;

    // On-time in steps for a 64-step slot, scaled to other slot lengths.
    function automatic int on_steps(input logic [2:0] code, input int slot_len);
        int base;
        case (code)
            3'd0: base = 64;
            3'd1: base = 34;
            3'd2: base = 26;
            3'd3: base = 17;
            3'd4: base = 13;
            3'd5: base = 8;
            3'd6: base = 4;
            default: base = 0;
        endcase
        return (base * slot_len) / 64;
    endfunction

    typedef struct packed {
        logic       div16;
        logic [2:0] code;
        logic       peak;
    } scan_ctrl_t;

endpackage

// File: rtl/scan_prescale.sv
module scan_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic div_en,
    output logic adv
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(DIV - 1));
    assign adv  = tick && (!div_en || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!div_en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int ROWS = 7,
    parameter int SLOT = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    output logic [$clog2(SLOT)-1:0] slot_cnt,
    output logic [$clog2(ROWS)-1:0] row_idx,
    output logic [$clog2(ROWS)-1:0] next_row,
    output logic                    slot_end
);
    localparam int SW = $clog2(SLOT);
    localparam int RW = $clog2(ROWS);

    assign slot_end = adv && (slot_cnt == SW'(SLOT - 1));
    assign next_row = (row_idx == RW'(ROWS - 1)) ? '0 : row_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt <= '0;
            row_idx  <= '0;
        end else if (adv) begin
            slot_cnt <= slot_end ? '0 : slot_cnt + 1'b1;
            if (slot_end) begin
                row_idx <= next_row;
            end
        end
    end
endmodule

// File: rtl/scan_pwm.sv
module scan_pwm
    import scan_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int SLOT = 64
) (
    input  logic [$clog2(ROWS)-1:0] row_idx,
    input  logic [$clog2(SLOT)-1:0] slot_cnt,
    input  logic [2:0]              code,
    output logic [ROWS-1:0]         strobe
);
    localparam int OW = $clog2(SLOT) + 1;

    logic [OW-1:0] on_len;
    logic          lit;

    assign on_len = OW'(on_steps(code, SLOT));
    assign lit    = {1'b0, slot_cnt} < on_len;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign strobe[r] = lit && (row_idx == $clog2(ROWS)'(r));
    end
endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner
    import scan_pkg::*;
#(
    parameter int N_CHARS = 8,
    parameter int N_COLS  = 5,
    parameter int N_ROWS  = 7,
    parameter int SLOT    = 64,
    parameter int PRE_DIV = 16,
    localparam int COL_W  = N_CHARS * N_COLS,
    localparam int ROW_AW = $clog2(N_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mux_tick,
    input  logic              div16_en,
    input  logic [2:0]        bright_code,
    input  logic              peak_sel,
    output logic [ROW_AW-1:0] ram_rd_row,
    input  logic [COL_W-1:0]  ram_rd_data,
    output logic [N_ROWS-1:0] row_strobe,
    output logic [COL_W-1:0]  col_en,
    output logic              peak_flag
);
    localparam int SW = $clog2(SLOT);

    scan_ctrl_t         ctrl;
    logic               adv;
    logic               slot_end;
    logic [SW-1:0]      slot_cnt;
    logic [ROW_AW-1:0]  row_idx;
    logic [ROW_AW-1:0]  next_row;
    logic [COL_W-1:0]   col_q;
    logic               peak_q;

    assign ctrl = '{div16: div16_en, code: bright_code, peak: peak_sel};

    scan_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick   (mux_tick),
        .div_en (ctrl.div16),
        .adv    (adv)
    );

    scan_timer #(.ROWS(N_ROWS), .SLOT(SLOT)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .slot_cnt (slot_cnt),
        .row_idx  (row_idx),
        .next_row (next_row),
        .slot_end (slot_end)
    );

    scan_pwm #(.ROWS(N_ROWS), .SLOT(SLOT)) u_pwm (
        .row_idx  (row_idx),
        .slot_cnt (slot_cnt),
        .code     (ctrl.code),
        .strobe   (row_strobe)
    );

    // Prefetch: the next row's word is captured as the current slot ends.
    assign ram_rd_row = next_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            peak_q <= 1'b1;
        end else begin
            peak_q <= ctrl.peak;
            if (slot_end) begin
                col_q <= ram_rd_data;
            end
        end
    end

    assign col_en    = col_q;
    assign peak_flag = peak_q;
endmodule

// File: rtl/led_row_scanner_chk.sv
module led_row_scanner_chk #(
    parameter int N_ROWS = 7,
    parameter int COL_W  = 40,
    parameter int ROW_AW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mux_tick,
    input logic [2:0]        bright_code,
    input logic              peak_sel,
    input logic [ROW_AW-1:0] ram_rd_row,
    input logic [N_ROWS-1:0] row_strobe,
    input logic [COL_W-1:0]  col_en,
    input logic              peak_flag
);
    assert_single_row_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_strobe));

    assert_dark_powerdown_R5: assert property (@(posedge clk) disable iff (rst)
        (bright_code == 3'd7) |-> (row_strobe == '0));

    assert_full_duty_R4: assert property (@(posedge clk) disable iff (rst)
        (bright_code == 3'd0) |-> (row_strobe != '0));

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !mux_tick |=> ($stable(col_en) && $stable(ram_rd_row)));

    assert_peak_follow_R6: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(peak_sel) |=> (peak_flag == $past(peak_sel)));

    assert_restart_R10: assert property (@(posedge clk)
        rst |=> ((row_strobe[N_ROWS-1:1] == '0) && (col_en == '0)));
endmodule

bind led_row_scanner led_row_scanner_chk #(
    .N_ROWS (N_ROWS),
    .COL_W  (COL_W),
    .ROW_AW (ROW_AW)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mux_tick    (mux_tick),
    .bright_code (bright_code),
    .peak_sel    (peak_sel),
    .ram_rd_row  (ram_rd_row),
    .row_strobe  (row_strobe),
    .col_en      (col_en),
    .peak_flag   (peak_flag)
);

// File: tb/led_row_scanner_tb_top.sv
module led_row_scanner_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mux_tick = 1'b0;
    logic        div16_en = 1'b0;
    logic [2:0]  bright_code = 3'd0;
    logic        peak_sel = 1'b1;
    logic [2:0]  ram_rd_row;
    logic [39:0] ram_rd_data;
    logic [6:0]  row_strobe;
    logic [39:0] col_en;
    logic        peak_flag;

    logic [39:0] mem [0:6];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign ram_rd_data = (ram_rd_row < 3'd7) ? mem[ram_rd_row] : 40'd0;

    led_row_scanner dut_i (
        .clk         (clk),
        .rst         (rst),
        .mux_tick    (mux_tick),
        .div16_en    (div16_en),
        .bright_code (bright_code),
        .peak_sel    (peak_sel),
        .ram_rd_row  (ram_rd_row),
        .ram_rd_data (ram_rd_data),
        .row_strobe  (row_strobe),
        .col_en      (col_en),
        .peak_flag   (peak_flag)
    );

    function automatic int exp_on(input int code);
        int t [8] = '{64, 34, 26, 17, 13, 8, 4, 0};
        return t[code];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mux_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            mux_tick = 1'b1;
        end
        @(negedge clk);
        mux_tick = 1'b0;
    endtask

    task automatic fill_mem(input logic [39:0] salt);
        for (int r = 0; r < 7; r++)
            mem[r] = 40'h0F1E2D3C4B ^ (40'(r + 1) * 40'h0108421084) ^ salt;
    endtask

    task automatic t_reset();
        bright_code = 3'd0;
        do_reset();
        check(row_strobe == 7'b0000001, "R1 strobe", 64'(row_strobe), 64'h1);
        check(col_en == 40'd0, "R1 columns", 64'(col_en), 64'h0);
    endtask

    task automatic t_scan_order();
        bright_code = 3'd0;
        do_reset();
        ticks(1);
        for (int s = 0; s < 14; s++) begin
            int r = s % 7;
            logic [39:0] e = (s == 0) ? 40'd0 : mem[r];
            check(row_strobe == 7'(1 << r), "R2 row order", 64'(row_strobe), 64'(1 << r));
            check(col_en == e, "R3 row data", 64'(col_en), 64'(e));
            ticks(64);
        end
    endtask

    task automatic t_duty();
        for (int c = 0; c < 8; c++) begin
            int on = 0;
            bit stray = 1'b0;
            bright_code = 3'(c);
            do_reset();
            for (int k = 0; k < 64; k++) begin
                if (row_strobe != 0) on++;
                if ((row_strobe & 7'b1111110) != 0) stray = 1'b1;
                ticks(1);
            end
            check(on == exp_on(c), "R4 on-time", 64'(on), 64'(exp_on(c)));
            check(!stray, "R2 only row 0 in first slot", 64'(stray), 64'h0);
        end
    endtask

    task automatic t_powerdown();
        int lit = 0;
        logic [39:0] nw = 40'hA5A5A5A5A5;
        bright_code = 3'd7;
        peak_sel = 1'b1;
        do_reset();
        for (int k = 0; k < 448; k++) begin
            if (k == 100) mem[3] = nw;
            if (row_strobe != 0) lit++;
            ticks(1);
        end
        check(lit == 0, "R5 dark frame", 64'(lit), 64'h0);
        bright_code = 3'd2;
        #1;
        check(row_strobe == 7'b0000001, "R5 relight", 64'(row_strobe), 64'h1);
        ticks(3 * 64);
        check(col_en == nw, "R5 data kept", 64'(col_en), 64'(nw));
        bright_code = 3'd0;
        fill_mem(40'd0);
    endtask

    task automatic t_peak();
        bright_code = 3'd3;
        do_reset();
        @(negedge clk);
        peak_sel = 1'b0;
        @(negedge clk);
        check(peak_flag == 1'b0, "R6 reduced", 64'(peak_flag), 64'h0);
        check(row_strobe == 7'b0000001, "R6 duty unaffected", 64'(row_strobe), 64'h1);
        peak_sel = 1'b1;
        @(negedge clk);
        check(peak_flag == 1'b1, "R6 full", 64'(peak_flag), 64'h1);
        bright_code = 3'd0;
    endtask

    task automatic t_prescale();
        div16_en = 1'b1;
        bright_code = 3'd0;
        do_reset();
        ticks(64 * 16 - 1);
        check(row_strobe == 7'b0000001, "R7 still row 0", 64'(row_strobe), 64'h1);
        ticks(1);
        check(row_strobe == 7'b0000010, "R7 row 1 after 1024", 64'(row_strobe), 64'h2);
        check(col_en == mem[1], "R7 row 1 data", 64'(col_en), 64'(mem[1]));
        div16_en = 1'b0;
        ticks(1);
        check(row_strobe == 7'b0000010, "R7 undivided step", 64'(row_strobe), 64'h2);
    endtask

    task automatic t_mid_write();
        logic [39:0] old;
        logic [39:0] nw = 40'h123456789A;
        bright_code = 3'd0;
        do_reset();
        ticks(2 * 64 + 10);
        old = mem[2];
        mem[2] = nw;
        ticks(20);
        check(col_en == old, "R8 held mid slot", 64'(col_en), 64'(old));
        ticks(34 + 6 * 64);
        check(col_en == nw, "R8 shown next visit", 64'(col_en), 64'(nw));
        fill_mem(40'd0);
    endtask

    task automatic t_no_tick();
        logic [39:0] c0;
        logic [6:0]  s0;
        bright_code = 3'd0;
        do_reset();
        ticks(63);
        c0 = col_en;
        s0 = row_strobe;
        repeat (100) @(negedge clk);
        check(col_en == c0 && row_strobe == s0, "R9 idle hold",
              64'({row_strobe, col_en}), 64'({s0, c0}));
        ticks(1);
        check(row_strobe == 7'b0000010, "R9 resumes", 64'(row_strobe), 64'h2);
    endtask

    task automatic t_mid_reset();
        bright_code = 3'd0;
        do_reset();
        ticks(4 * 64 + 7);
        do_reset();
        check(row_strobe == 7'b0000001, "R10 row 0", 64'(row_strobe), 64'h1);
        check(col_en == 40'd0, "R10 cleared", 64'(col_en), 64'h0);
        ticks(64);
        check(row_strobe == 7'b0000010, "R10 full slot", 64'(row_strobe), 64'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        fill_mem(40'd0);
        t_reset();
        t_scan_order();
        t_duty();
        t_powerdown();
        t_peak();
        t_prescale();
        t_mid_write();
        t_no_tick();
        t_mid_reset();
        finish_run();
    end

endmodule